// File: doc/BRIEF.md
# Two-Line Secondary Interrupt Collector

This block gathers a parameterizable number of event inputs and turns them into interrupt requests on two independent host lines. Each event is first brought into the clock domain through a two-flop synchronizer. It then passes through a per-event edge filter that can capture rising edges, falling edges, both, or neither. A captured edge sets a status bit in each line's status register. Each line owns its own status and mask registers, so two host controllers can service the same events independently. The edge filter settings are common to both lines.

Software reaches the block through a small synchronous byte-wide register port. A shared control byte chooses how status bits are cleared: either a read clears the bits it returned, or software writes ones to clear them. The control byte also chooses whether an event that arrives while its status bit is still set is held and replayed after the bit clears. Two write-only force registers, one per line, let test code set status bits directly. Each line drives an active-low request output that is asserted while any unmasked status bit of that line is set.

Top module: `irq_sih_bank`

## Requirements
- R1: Event i is configured by two bits of the edge register: byte i>>2 (at address 0x20 + (i>>2)), bit offset (i&3)*2. The upper bit of the pair enables rising-edge capture and the lower bit enables falling-edge capture. The edge register reads back what was written.
- R2: An event whose two edge bits are 00 never sets status on either line. The edge register resets to all zeros.
- R3: Line 0 has its status bytes at 0x04.. and its mask bytes at 0x08... Line 1 has its status bytes at 0x0C.. and its mask bytes at 0x10... A captured edge sets the event's status bit on both lines. Each line's status is then kept and cleared independently of the other line's.
- R4: A mask bit of 1 keeps its status bit from driving irq_n of that line. irq_n[l] is low exactly when some status bit of line l is set while its mask bit is 0. Mask bits reset to 1, and status bits reset to 0. Bits above the event count read as 0.
- R5: When control bit 0 (0x00) is 1, a read of a status byte returns its value and clears the set bits of that byte on that line only.
- R6: When control bit 0 is 0, writing 1 to a status bit clears it, and writing 0 leaves it alone. Reads do not clear.
- R7: Control bit 1 disables buffering. When it is 0, an edge that arrives while its status bit is already set is held, and that bit sets again on the cycle it is cleared. When it is 1, such an edge is dropped.
- R8: Writing 1 to a bit of a force register sets the matching status bit of that line only. The force register for line 0 is at 0x14.. and the one for line 1 is at 0x18... Force registers read as 0.
- R9: When a captured edge and a clear of the same status bit happen in the same cycle, the bit stays set.
- R10: A read of an address that is not defined returns 0, and a write to such an address changes no state.
- R11: An input change presented before clock edge k sets status at edge k+2, so irq_n responds after the third edge. Read data appears on the clock edge after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | N_EVT | Asynchronous event inputs |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_n | output | 2 | Active-low request, one per host line |

## Verification
The edge-off assertion assumes that the edge setting of an event is never changed to 00 while a held event is waiting for that event. A replayed event could otherwise raise a status bit that has no visible cause. The stimulus meets this assumption: it uses buffering only on an event whose rising-edge setting stays fixed until the held event has been drained. The assertions also assume that reads and writes are never strobed in the same cycle. Every bus task in the bench drives only one of the two strobes at a time.

// File: rtl/irq_bank_pkg.sv
// Package: address map and control bit positions shared by the bank and its bench users.
// Assumes at most 32 events, so every register window fits in its slot.
package irq_bank_pkg;
    localparam int ADDR_CTRL   = 'h00;
    localparam int ADDR_STAT0  = 'h04;
    localparam int ADDR_MASK0  = 'h08;
    localparam int ADDR_STAT1  = 'h0C;
    localparam int ADDR_MASK1  = 'h10;
    localparam int ADDR_FORCE0 = 'h14;
    localparam int ADDR_FORCE1 = 'h18;
    localparam int ADDR_EDGE   = 'h20;
    localparam int CTRL_COR    = 0;
    localparam int CTRL_PDIS   = 1;
endpackage

// File: rtl/irq_edge_sense.sv
// Module: synchronizes each event input through two flops and detects the edges
// that its two-bit setting enables (upper bit rising, lower bit falling).
// Assumes the event inputs are asynchronous levels that are held for more than one clock.
module irq_edge_sense #(
    parameter int N = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt_in,
    input  logic [2*N-1:0]   edge_cfg,
    output logic [N-1:0]     hit
);
    logic [N-1:0] sync_a, sync_b, last_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            last_q <= '0;
        end else begin
            sync_a <= evt_in;
            sync_b <= sync_a;
            last_q <= sync_b;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_evt
        // Qualify the rising and falling transitions with the event's edge setting.
        assign hit[g] = (sync_b[g] & ~last_q[g] & edge_cfg[2*g+1])
                      | (~sync_b[g] & last_q[g] & edge_cfg[2*g]);
    end
endmodule

// File: rtl/irq_line_ctl.sv
// Module: status, held-event and mask state of one host line, plus its active-low request.
// Assumes the byte strobes come from a decoder that never asserts a read and a write together.
module irq_line_ctl #(
    parameter int N  = 12,
    parameter int SB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  hit,
    input  logic          cor,
    input  logic          buf_en,
    input  logic [7:0]    wdata,
    input  logic [SB-1:0] stat_rd,
    input  logic [SB-1:0] stat_wr,
    input  logic [SB-1:0] mask_wr,
    input  logic [SB-1:0] force_wr,
    output logic [N-1:0]  status,
    output logic [N-1:0]  mask,
    output logic          irq_n
);
    logic [N-1:0] stat_q, pend_q, mask_q, stat_d, pend_d, clr, setb;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Clear comes from a read in clear-on-read mode or a write of one otherwise.
        assign clr[g]  = cor ? stat_rd[g/8] : (stat_wr[g/8] & wdata[g%8]);
        // A set comes from a captured edge or a forced test write.
        assign setb[g] = hit[g] | (force_wr[g/8] & wdata[g%8]);
        // A set wins over a clear; a held event reloads the bit when it clears.
        assign stat_d[g] = clr[g] ? (setb[g] | pend_q[g]) : (stat_q[g] | setb[g]);
        // The held event is kept only while buffering is enabled.
        assign pend_d[g] = buf_en & (clr[g] ? (pend_q[g] & setb[g])
                                            : (pend_q[g] | (stat_q[g] & setb[g])));

        // Mask bit storage, all blocking after reset.
        always_ff @(posedge clk) begin
            if (!rst_n)          mask_q[g] <= 1'b1;
            else if (mask_wr[g/8]) mask_q[g] <= wdata[g%8];
        end

        // R6 with R5: a clear with no competing set or held event empties the bit.
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !setb[g] && !pend_q[g]) |=> !stat_q[g]);
        // R9: a set in the same cycle as a clear keeps the bit.
        p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && setb[g]) |=> stat_q[g]);
        // R7: a held event reloads the bit on clear.
        p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && pend_q[g] && buf_en) |=> stat_q[g]);
        // R7: with buffering off, an unopposed clear always empties the bit.
        p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !setb[g] && !buf_en) |=> !stat_q[g]);
    end

    // Status and held-event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            pend_q <= '0;
        end else begin
            stat_q <= stat_d;
            pend_q <= pend_d;
        end
    end

    assign status = stat_q;
    assign mask   = mask_q;
    assign irq_n  = ~|(stat_q & ~mask_q);

    // R4: a fully masked line never requests.
    p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> irq_n);
endmodule

// File: rtl/irq_sih_bank.sv
// Module: top of the two-line collector. Decodes the byte register port, holds the shared
// control and edge registers, and instantiates the edge sensing and one controller per line.
// Assumes N_EVT <= 32 and that reg_rd and reg_wr are never asserted together.
module irq_sih_bank
    import irq_bank_pkg::*;
#(
    parameter int N_EVT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_in,
    input  logic [7:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_rd,
    output logic [7:0]       reg_rdata,
    output logic [1:0]       irq_n
);
    localparam int SB = (N_EVT + 7) / 8;
    localparam int EB = (2 * N_EVT + 7) / 8;
    localparam int SW = SB * 8;
    localparam int EW = EB * 8;
    localparam logic [EW-1:0] EDGE_VALID = ~({EW{1'b1}} << (2 * N_EVT));

    logic [1:0]       ctrl_q;
    logic [EW-1:0]    edge_q;
    logic [N_EVT-1:0] hit;
    logic [N_EVT-1:0] stat_v [2];
    logic [N_EVT-1:0] mask_v [2];
    logic [SW-1:0]    st_pad [2];
    logic [SW-1:0]    mk_pad [2];
    logic [7:0]       rd_mux;
    logic             rd_hit;

    irq_edge_sense #(.N(N_EVT)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .edge_cfg (edge_q[2*N_EVT-1:0]),
        .hit      (hit)
    );

    for (genvar l = 0; l < 2; l++) begin : g_line
        localparam int B_ST = (l == 0) ? ADDR_STAT0  : ADDR_STAT1;
        localparam int B_MK = (l == 0) ? ADDR_MASK0  : ADDR_MASK1;
        localparam int B_FR = (l == 0) ? ADDR_FORCE0 : ADDR_FORCE1;
        logic [SB-1:0] st_rd, st_wr, mk_wr, fr_wr;

        // Byte strobes of this line's status, mask and force windows.
        always_comb begin
            for (int b = 0; b < SB; b++) begin
                st_rd[b] = reg_rd && (reg_addr == 8'(B_ST + b));
                st_wr[b] = reg_wr && (reg_addr == 8'(B_ST + b));
                mk_wr[b] = reg_wr && (reg_addr == 8'(B_MK + b));
                fr_wr[b] = reg_wr && (reg_addr == 8'(B_FR + b));
            end
        end

        irq_line_ctl #(.N(N_EVT), .SB(SB)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit),
            .cor      (ctrl_q[CTRL_COR]),
            .buf_en   (~ctrl_q[CTRL_PDIS]),
            .wdata    (reg_wdata),
            .stat_rd  (st_rd),
            .stat_wr  (st_wr),
            .mask_wr  (mk_wr),
            .force_wr (fr_wr),
            .status   (stat_v[l]),
            .mask     (mask_v[l]),
            .irq_n    (irq_n[l])
        );

        assign st_pad[l] = SW'(stat_v[l]);
        assign mk_pad[l] = SW'(mask_v[l]);
    end

    // Control and edge register writes; bits beyond the event count stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            edge_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == 8'(ADDR_CTRL)) ctrl_q <= reg_wdata[1:0];
            for (int b = 0; b < EB; b++)
                if (reg_addr == 8'(ADDR_EDGE + b))
                    edge_q[8*b +: 8] <= reg_wdata & EDGE_VALID[8*b +: 8];
        end
    end

    // Read multiplexer; force windows decode but read as zero.
    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b0;
        if (reg_addr == 8'(ADDR_CTRL)) begin
            rd_mux = {6'b0, ctrl_q};
            rd_hit = 1'b1;
        end
        for (int b = 0; b < SB; b++) begin
            if (reg_addr == 8'(ADDR_STAT0 + b)) begin rd_mux = st_pad[0][8*b +: 8]; rd_hit = 1'b1; end
            if (reg_addr == 8'(ADDR_STAT1 + b)) begin rd_mux = st_pad[1][8*b +: 8]; rd_hit = 1'b1; end
            if (reg_addr == 8'(ADDR_MASK0 + b)) begin rd_mux = mk_pad[0][8*b +: 8]; rd_hit = 1'b1; end
            if (reg_addr == 8'(ADDR_MASK1 + b)) begin rd_mux = mk_pad[1][8*b +: 8]; rd_hit = 1'b1; end
            if (reg_addr == 8'(ADDR_FORCE0 + b) || reg_addr == 8'(ADDR_FORCE1 + b)) rd_hit = 1'b1;
        end
        for (int b = 0; b < EB; b++)
            if (reg_addr == 8'(ADDR_EDGE + b)) begin rd_mux = edge_q[8*b +: 8]; rd_hit = 1'b1; end
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R10: an undefined read returns zero.
    p_rd_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rd_hit) |=> (reg_rdata == 8'h00));

    for (genvar i = 0; i < N_EVT; i++) begin : g_chk
        // R2: line 0 status rises only after an enabled edge setting or a forced write.
        p_edge_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_v[0][i]) |->
                (($past(edge_q[2*i +: 2]) != 2'b00) ||
                 $past(reg_wr && (reg_addr == 8'(ADDR_FORCE0 + i/8)) && reg_wdata[i%8])));
    end
endmodule

// File: tb/irq_sih_bank_bench.sv
`timescale 1ns/1ps
module irq_sih_bank_bench;
    localparam int N = 12;
    localparam logic [7:0] A_CTRL = 8'h00, A_ST0 = 8'h04, A_MK0 = 8'h08, A_ST1 = 8'h0C,
                           A_MK1 = 8'h10, A_FR0 = 8'h14, A_FR1 = 8'h18, A_EDGE = 8'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt_in = '0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] irq_n;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    irq_sih_bank #(.N_EVT(N)) u_irq_sih_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_ST0, 8'hFF); wr(A_ST0 + 8'd1, 8'hFF);
        wr(A_ST1, 8'hFF); wr(A_ST1 + 8'd1, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        idle(4); rst_n = 1'b1; idle(1);

        // Reset state (R2, R4)
        chk("R4 irq_n reset", irq_n, 2'b11);
        rd(A_CTRL, d); chk("R4 ctrl reset", d, 0);
        rd(A_ST0, d); chk("R4 status reset", d, 0);
        rd(A_MK0, d); chk("R4 mask reset lo", d, 8'hFF);
        rd(A_MK0 + 8'd1, d); chk("R4 mask reset hi", d, 8'h0F);
        rd(A_EDGE + 8'd1, d); chk("R2 edge reset", d, 0);

        // Sweep of every event and edge code (R1, R2, R3, R4)
        wr(A_MK0, 8'h00); wr(A_MK0 + 8'd1, 8'h00);
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] eb, exp;
                eb = 8'(c << ((i & 3) * 2));
                for (int b = 0; b < 3; b++) wr(A_EDGE + 8'(b), (b == (i >> 2)) ? eb : 8'h00);
                rd(A_EDGE + 8'(i >> 2), d); chk("R1 edge readback", d, eb);
                evt_in[i] = 1'b1; idle(4);
                exp = c[1] ? 8'(1 << (i & 7)) : 8'h00;
                rd(A_ST0 + 8'(i >> 3), d); chk("R1/R2 rising status line0", d, exp);
                rd(A_ST1 + 8'(i >> 3), d); chk("R3 rising status line1", d, exp);
                chk("R4 irq_n line0", irq_n[0], !c[1]);
                chk("R3 irq_n line1 masked", irq_n[1], 1'b1);
                clear_all();
                evt_in[i] = 1'b0; idle(4);
                exp = c[0] ? 8'(1 << (i & 7)) : 8'h00;
                rd(A_ST0 + 8'(i >> 3), d); chk("R1/R2 falling status", d, exp);
                clear_all();
            end
        end
        for (int b = 0; b < 3; b++) wr(A_EDGE + 8'(b), 8'h00);

        // Mask gating (R4)
        wr(A_FR0, 8'h20); wr(A_MK0, 8'h20); idle(1);
        chk("R4 masked bit no request", irq_n[0], 1'b1);
        wr(A_MK0, 8'h00); idle(1);
        chk("R4 unmasked bit requests", irq_n[0], 1'b0);
        clear_all();

        // Force register (R8)
        wr(A_FR1 + 8'd1, 8'h02);
        rd(A_ST1 + 8'd1, d); chk("R8 force line1", d, 8'h02);
        rd(A_ST0 + 8'd1, d); chk("R8 force other line", d, 8'h00);
        rd(A_FR1 + 8'd1, d); chk("R8 force reads zero", d, 8'h00);
        clear_all();

        // Clear on read (R5)
        wr(A_CTRL, 8'h01);
        wr(A_FR0, 8'h08); wr(A_FR1, 8'h08);
        rd(A_ST0, d); chk("R5 read returns", d, 8'h08);
        rd(A_ST0, d); chk("R5 read cleared", d, 8'h00);
        rd(A_ST1, d); chk("R5 other line kept", d, 8'h08);
        rd(A_ST1, d);

        // Write one to clear (R6)
        wr(A_CTRL, 8'h00);
        wr(A_FR0, 8'h06); wr(A_ST0, 8'h02);
        rd(A_ST0, d); chk("R6 w1c partial", d, 8'h04);
        rd(A_ST0, d); chk("R6 read no clear", d, 8'h04);
        clear_all();

        // Buffering (R7): event 2 rising
        wr(A_EDGE, 8'h20);
        evt_in[2] = 1'b1; idle(4); evt_in[2] = 1'b0; idle(4);
        evt_in[2] = 1'b1; idle(4); evt_in[2] = 1'b0; idle(4);
        wr(A_ST0, 8'h04);
        rd(A_ST0, d); chk("R7 held event reloads", d, 8'h04);
        wr(A_ST0, 8'h04);
        rd(A_ST0, d); chk("R7 drained", d, 8'h00);
        clear_all();
        wr(A_CTRL, 8'h02);
        evt_in[2] = 1'b1; idle(4); evt_in[2] = 1'b0; idle(4);
        evt_in[2] = 1'b1; idle(4); evt_in[2] = 1'b0; idle(4);
        wr(A_ST0, 8'h04);
        rd(A_ST0, d); chk("R7 disabled drops", d, 8'h00);
        clear_all();

        // Edge and clear in the same cycle (R9)
        wr(A_FR0, 8'h04);
        evt_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        reg_addr = A_ST0; reg_wdata = 8'h04; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(A_ST0, d); chk("R9 edge beats clear", d, 8'h04);
        evt_in[2] = 1'b0; idle(4);
        clear_all();

        // Latency (R11)
        idle(1);
        evt_in[2] = 1'b1;
        @(negedge clk); chk("R11 after edge1", irq_n[0], 1'b1);
        @(negedge clk); chk("R11 after edge2", irq_n[0], 1'b1);
        @(negedge clk); chk("R11 after edge3", irq_n[0], 1'b0);
        evt_in[2] = 1'b0; idle(4);
        clear_all();
        wr(A_EDGE, 8'h00);

        // Undefined addresses (R10)
        wr(A_FR0, 8'h10);
        wr(8'h30, 8'hFF); wr(8'h03, 8'hFF);
        rd(8'h30, d); chk("R10 undefined read", d, 8'h00);
        rd(8'h03, d); chk("R10 gap read", d, 8'h00);
        rd(A_ST0, d); chk("R10 status untouched", d, 8'h10);
        rd(A_CTRL, d); chk("R10 ctrl untouched", d, 8'h02);
        rd(A_MK0, d); chk("R10 mask untouched", d, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule